// File: doc/BRIEF.md
# Presettable Cascadable Down Counter

A four-bit synchronous down counter for frequency division. Each counting event lowers the count by one. A counting event is either a rising edge of the count-clock line or a falling edge of the inhibit line. Both lines are treated as asynchronous. They pass through synchronisers and are edge-detected on a fast system clock. A parallel preset value is loaded whenever the load-enable input is high. A decoded zero output goes high when the count is zero and the chain-qualify input is high.

For a single-stage divide-by-N, the zero output drives load-enable, the preset is N and chain-qualify is tied high. The zero output then pulses once every N counting events.

Two stages can be chained with no extra logic:
- The lower stage's count-clock is driven by the external events.
- Its chain-qualify input comes from the upper stage's zero output.
- The upper stage's count-clock is driven by the lower stage's most significant count bit.
- The lower stage's zero output drives load-enable on both stages.

The pair then divides by 16×M+N, where M is the upper preset and N is the lower preset.

Top module: `dnctr_stage`

## Requirements
- R1: Each counting event lowers `count_o` by exactly one, modulo 16.
- R2: A counting event is a synchronised rising edge of `tick_i` while the synchronised `hold_i` is low, or a synchronised falling edge of `hold_i`. A rising edge of `hold_i` is not an event.
- R3: While `hold_i` stays high, rising edges of `tick_i` leave `count_o` unchanged.
- R4: While `load_i` is high, each system clock edge copies `preset_i` into the count. Loading takes priority over any counting event in that cycle.
- R5: `rst` high clears the count to 0 on the next system clock edge. Reset takes priority over `load_i`.
- R6: `zero_o` is 1 exactly when `count_o` is 0 and `chain_i` is 1. It is 0 whenever `chain_i` is 0.
- R7: A counting event at count 0 with `load_i` low gives count 15.
- R8: After a change on `tick_i` or `hold_i` that forms an event, `count_o` takes its new value at the third rising system clock edge. It is unchanged after the first and second edges.
- R9: With `zero_o` fed to `load_i`, `chain_i` high and preset N (2 to 15), `zero_o` is high for one system cycle once every N events.
- R10: In the two-stage chain with upper preset M and lower preset N in the range 0 to 7, the chain's zero output pulses once every 16×M+N events.
- R11: A rising `tick_i` edge and a falling `hold_i` edge that reach the synchronised domain in the same system cycle lower the count by one only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count-clock line; rising edge is an event unless inhibited |
| hold_i | input | 1 | Inhibit line; high blocks `tick_i`, falling edge is an event |
| load_i | input | 1 | Load-enable; high copies `preset_i` into the count |
| preset_i | input | 4 | Parallel preset value |
| chain_i | input | 1 | Chain-qualify for the zero output |
| count_o | output | 4 | Current count |
| zero_o | output | 1 | Decoded zero, qualified by `chain_i` |

## Verification
An input edge reaches `count_o` at the third rising system edge: two synchroniser flops, then the count register. A change on `load_i` or `rst` takes effect at the very next edge, and `zero_o` follows the count with no register. The bench drives inputs on falling edges. It holds every count-clock or inhibit level for four system cycles, so each event has settled before the next check. The latency check for R8 samples at the falling edges just after the second and third rising edges. Zero pulses last one system cycle, so a monitor counts them on every rising edge rather than sampling them at check points.

// File: rtl/dnctr_pkg.sv
package dnctr_pkg;

    parameter int CNT_W = 4;

    typedef logic [CNT_W-1:0] cnt_t;

    // Operation applied to the count register on one system cycle
    typedef enum logic [1:0] {
        OP_KEEP,
        OP_STEP,
        OP_LOAD,
        OP_CLEAR
    } op_e;

    typedef struct packed {
        logic clear;
        logic load;
        logic step;
    } req_t;

    // Priority: clear, then load, then step
    function automatic op_e pick_op(req_t r);
        if (r.clear)
            return OP_CLEAR;
        else if (r.load)
            return OP_LOAD;
        else if (r.step)
            return OP_STEP;
        return OP_KEEP;
    endfunction

    function automatic cnt_t step_down(cnt_t v);
        return v - cnt_t'(1);
    endfunction

endpackage

// File: rtl/dnctr_sync.sv
module dnctr_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] d,
    output logic [LINES-1:0] q
);

    logic [LINES-1:0] pipe [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst)
                    pipe[0] <= '0;
                else
                    pipe[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst)
                    pipe[s] <= '0;
                else
                    pipe[s] <= pipe[s-1];
            end
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/dnctr_edge.sv
module dnctr_edge (
    input  logic clk,
    input  logic rst,
    input  logic tick_s,
    input  logic hold_s,
    output logic step
);

    logic tick_d;
    logic hold_d;
    logic tick_rise;
    logic hold_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_d <= 1'b0;
            hold_d <= 1'b0;
        end else begin
            tick_d <= tick_s;
            hold_d <= hold_s;
        end
    end

    assign tick_rise = tick_s & ~tick_d;
    assign hold_fall = hold_d & ~hold_s;

    // Both sources merge into one step, so coincident edges give one decrement
    assign step = (tick_rise & ~hold_s) | hold_fall;

endmodule

// File: rtl/dnctr_core.sv
module dnctr_core
    import dnctr_pkg::*;
(
    input  logic clk,
    input  req_t req,
    input  cnt_t preset,
    output cnt_t count
);

    op_e  op;
    cnt_t nxt;

    assign op = pick_op(req);

    always_comb begin
        case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = preset;
            OP_STEP:  nxt = step_down(count);
            default:  nxt = count;
        endcase
    end

    always_ff @(posedge clk) begin
        count <= nxt;
    end

endmodule

// File: rtl/dnctr_stage.sv
module dnctr_stage
    import dnctr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             hold_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] preset_i,
    input  logic             chain_i,
    output logic [CNT_W-1:0] count_o,
    output logic             zero_o
);

    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] sync_lines;
    logic               tick_sync;
    logic               hold_sync;
    logic               step;
    req_t               req;
    cnt_t               count;

    assign raw_lines = {hold_i, tick_i};

    dnctr_sync #(
        .LINES  (N_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_lines),
        .q   (sync_lines)
    );

    assign tick_sync = sync_lines[0];
    assign hold_sync = sync_lines[1];

    dnctr_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .tick_s (tick_sync),
        .hold_s (hold_sync),
        .step   (step)
    );

    assign req = '{clear: rst, load: load_i, step: step};

    dnctr_core u_core (
        .clk    (clk),
        .req    (req),
        .preset (preset_i),
        .count  (count)
    );

    assign count_o = count;
    assign zero_o  = chain_i & (count == '0);

endmodule

// File: rtl/dnctr_chk.sv
module dnctr_chk
    import dnctr_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic load_i,
    input logic [CNT_W-1:0] preset_i,
    input logic [CNT_W-1:0] count_o,
    input logic zero_o,
    input logic step,
    input logic hold_sync
);

    // R5: reset clears the count regardless of load
    a_r5_reset_clears: assert property (@(posedge clk)
        rst |=> count_o == '0);

    // R4: load copies the preset and wins over a step
    a_r4_load_wins: assert property (@(posedge clk) disable iff (rst)
        load_i |=> count_o == $past(preset_i));

    // R1: a step without load lowers the count by one (R7 wrap included)
    a_r1_step_down: assert property (@(posedge clk) disable iff (rst)
        (!load_i && step) |=> count_o == cnt_t'($past(count_o) - 1'b1));

    // R1: no step and no load keeps the count
    a_r1_no_step_keeps: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !step) |=> $stable(count_o));

    // R3: inhibit held high across a cycle produces no step
    a_r3_hold_blocks: assert property (@(posedge clk) disable iff (rst)
        (hold_sync && $past(hold_sync)) |-> !step);

    // R6: zero output only with a zero count
    a_r6_zero_needs_zero: assert property (@(posedge clk) disable iff (rst)
        zero_o |-> count_o == '0);

endmodule

bind dnctr_stage dnctr_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .load_i    (load_i),
    .preset_i  (preset_i),
    .count_o   (count_o),
    .zero_o    (zero_o),
    .step      (step),
    .hold_sync (hold_sync)
);

// File: tb/sim_dnctr_stage.sv
module sim_dnctr_stage;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       hold = 1'b0;
    logic       load_drv = 1'b0;
    logic       fb = 1'b0;
    logic [3:0] preset = 4'd0;
    logic       chain = 1'b1;
    logic [3:0] count;
    logic       zero;
    logic       load_sel;

    int checks = 0;
    int errors = 0;
    int zc = 0;

    always #10 clk = ~clk;

    assign load_sel = fb ? zero : load_drv;

    dnctr_stage u0 (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick),
        .hold_i   (hold),
        .load_i   (load_sel),
        .preset_i (preset),
        .chain_i  (chain),
        .count_o  (count),
        .zero_o   (zero)
    );

    // Two-stage chain
    logic       c_rst = 1'b1;
    logic       c_tick = 1'b0;
    logic [3:0] c_m = 4'd0;
    logic [3:0] c_n = 4'd0;
    logic [3:0] hi_cnt;
    logic [3:0] lo_cnt;
    logic       hi_zero;
    logic       lo_zero;
    int         czc = 0;

    dnctr_stage u_hi (
        .clk      (clk),
        .rst      (c_rst),
        .tick_i   (lo_cnt[3]),
        .hold_i   (1'b0),
        .load_i   (lo_zero),
        .preset_i (c_m),
        .chain_i  (1'b1),
        .count_o  (hi_cnt),
        .zero_o   (hi_zero)
    );

    dnctr_stage u_lo (
        .clk      (clk),
        .rst      (c_rst),
        .tick_i   (c_tick),
        .hold_i   (1'b0),
        .load_i   (lo_zero),
        .preset_i (c_n),
        .chain_i  (hi_zero),
        .count_o  (lo_cnt),
        .zero_o   (lo_zero)
    );

    always @(posedge clk) begin
        if (!rst && zero) zc <= zc + 1;
        if (!c_rst && lo_zero) czc <= czc + 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_tick();
        @(negedge clk) tick = 1'b1;
        repeat (4) @(negedge clk);
        tick = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_hold();
        @(negedge clk) hold = 1'b1;
        repeat (4) @(negedge clk);
        hold = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_chain();
        @(negedge clk) c_tick = 1'b1;
        repeat (4) @(negedge clk);
        c_tick = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_load(input logic [3:0] v);
        @(negedge clk) begin
            preset = v;
            load_drv = 1'b1;
        end
        @(negedge clk) load_drv = 1'b0;
    endtask

    // {use_hold, preset, events, expected count}
    localparam logic [12:0] VEC [8] = '{
        {1'b0, 4'd9,  4'd3,  4'd6},
        {1'b1, 4'd9,  4'd3,  4'd6},
        {1'b0, 4'd15, 4'd15, 4'd0},
        {1'b1, 4'd2,  4'd5,  4'd13},
        {1'b0, 4'd0,  4'd1,  4'd15},
        {1'b1, 4'd7,  4'd0,  4'd7},
        {1'b0, 4'd4,  4'd4,  4'd0},
        {1'b0, 4'd1,  4'd9,  4'd8}
    };

    localparam logic [7:0] CHAIN_VEC [3] = '{
        {4'd2, 4'd5},
        {4'd1, 4'd3},
        {4'd3, 4'd0}
    };

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int base;

        do_reset();
        // R5 reset state, R6 zero with chain high
        chk("R5 reset count", count, 0);
        chk("R6 zero at reset", zero, 1);

        // R1 R2 R7 table
        for (int i = 0; i < 8; i++) begin
            do_load(VEC[i][11:8]);
            for (int k = 0; k < int'(VEC[i][7:4]); k++) begin
                if (VEC[i][12]) pulse_hold();
                else pulse_tick();
            end
            chk(VEC[i][12] ? "R2 hold-fall events" : "R1 tick events",
                count, VEC[i][3:0]);
        end

        // R7 wrap
        do_load(4'd0);
        pulse_tick();
        chk("R7 wrap", count, 15);

        // R8 latency
        do_load(4'd10);
        @(negedge clk) tick = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R8 unchanged after 2 edges", count, 10);
        @(negedge clk);
        chk("R8 changed at 3rd edge", count, 9);
        repeat (3) @(negedge clk);
        tick = 1'b0;
        repeat (4) @(negedge clk);

        // R3 inhibit blocks tick; R2 falling hold counts
        do_load(4'd5);
        @(negedge clk) hold = 1'b1;
        repeat (4) @(negedge clk);
        pulse_tick();
        pulse_tick();
        pulse_tick();
        chk("R3 hold blocks tick", count, 5);
        @(negedge clk) hold = 1'b0;
        repeat (5) @(negedge clk);
        chk("R2 hold fall is event", count, 4);

        // R11 coincident edges
        do_load(4'd8);
        @(negedge clk) hold = 1'b1;
        repeat (4) @(negedge clk);
        hold = 1'b0;
        tick = 1'b1;
        repeat (6) @(negedge clk);
        chk("R11 one decrement", count, 7);
        tick = 1'b0;
        repeat (4) @(negedge clk);

        // R4 load wins over events
        @(negedge clk) begin
            preset = 4'd6;
            load_drv = 1'b1;
        end
        pulse_tick();
        chk("R4 load over step", count, 6);
        load_drv = 1'b0;

        // R5 reset wins over load
        @(negedge clk) begin
            preset = 4'd9;
            load_drv = 1'b1;
            rst = 1'b1;
        end
        @(negedge clk);
        chk("R5 reset over load", count, 0);
        rst = 1'b0;
        load_drv = 1'b0;
        @(negedge clk);

        // R6 chain qualify
        chain = 1'b0;
        #1;
        chk("R6 zero blocked by chain", zero, 0);
        chain = 1'b1;
        #1;
        chk("R6 zero with chain", zero, 1);

        // R9 single-stage divide-by-N
        fb = 1'b1;
        for (int n = 2; n <= 15; n++) begin
            preset = 4'(n);
            do_reset();
            base = zc;
            for (int k = 0; k < n - 1; k++) pulse_tick();
            chk($sformatf("R9 N=%0d no early pulse", n), zc - base, 0);
            pulse_tick();
            chk($sformatf("R9 N=%0d one pulse", n), zc - base, 1);
            for (int k = 0; k < n; k++) pulse_tick();
            chk($sformatf("R9 N=%0d second period", n), zc - base, 2);
        end
        fb = 1'b0;

        // R10 two-stage chain divide-by 16*M+N
        for (int j = 0; j < 3; j++) begin
            int period;
            c_m = CHAIN_VEC[j][7:4];
            c_n = CHAIN_VEC[j][3:0];
            period = 16 * int'(c_m) + int'(c_n);
            @(negedge clk) c_rst = 1'b1;
            repeat (2) @(negedge clk);
            c_rst = 1'b0;
            repeat (8) @(negedge clk);
            base = czc;
            for (int k = 0; k < period - 1; k++) pulse_chain();
            chk($sformatf("R10 period %0d no early pulse", period), czc - base, 0);
            pulse_chain();
            chk($sformatf("R10 period %0d one pulse", period), czc - base, 1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule